// File: doc/BRIEF.md
# Per-Instruction Stride Prefetch Table

This block watches the stream of load and store accesses leaving a core. It learns, for each instruction separately, the distance between consecutive addresses. Each access carries its program counter and data address. The low bits of the program counter select one entry of a direct-mapped table. That entry keeps the rest of the program counter as a tag, the previous address, the learned stride and a small confidence counter.

When the same stride keeps repeating, confidence builds up. The block then proposes the address that lies a fixed number of strides ahead of the current one. Because each instruction keeps its own stride, streams that are interleaved in time can still be predicted. Such streams show no common stride when viewed together.

Proposed addresses wait in a short queue. They leave it one per cycle, and only in cycles with no demand access. This way, demand traffic always takes priority over prefetch traffic.

Top module: `stride_pf_table`

## Requirements
- R1: After reset the queue is empty, `pf_valid` is low, and every table entry is invalid, so the first access of any program counter only allocates an entry.
- R2: The entry index is `acc_pc[3:0]` and the tag is the remaining upper bits. An access whose tag differs from the stored one, or that finds the entry invalid, takes over the entry: it stores the address, sets the stride and the counter to 0, and never issues a prefetch.
- R3: On a tag hit, the difference is the new address minus the stored address (modulo 2^32). The stored address is always replaced by the new one.
- R4: A difference equal to the stored stride raises the counter by one, saturating at 3. A different difference lowers the counter by one, stopping at 0. Whenever the updated counter is 0 after a mismatch, the stored stride is replaced by the new difference.
- R5: A tag hit whose updated counter is at least 2 and whose updated stride is nonzero queues the prefetch address: the current address plus 4 times the updated stride (modulo 2^32).
- R6: A zero stride never queues a prefetch, however high its counter.
- R7: `pf_valid` is never high while `acc_valid` is high. Queued addresses leave one per idle cycle, oldest first.
- R8: The queue holds 4 addresses. A prefetch that finds the queue full is dropped, and the queued addresses are kept.
- R9: Different program counters that map to different entries train independently, so interleaved strided streams each produce their own prefetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Demand access present this cycle |
| acc_pc | input | 32 | Program counter of the accessing instruction |
| acc_addr | input | 32 | Data address of the access |
| pf_valid | output | 1 | Prefetch address offered and taken this cycle |
| pf_addr | output | 32 | Oldest queued prefetch address |

## Verification
An access is sampled at a rising edge, and its prefetch, if any, enters the queue at that same edge. It can appear on `pf_valid` in the very next cycle, provided `acc_valid` is low then. While accesses keep coming, the queued prefetches stay held and come out one per idle cycle afterwards. The driver changes inputs just after the rising edge and records each expected address in order. The monitor samples at the falling edge, so every comparison falls in the idle cycle where the design is due to present that address. It also flags any prefetch offered during an access or not expected at all.

// File: rtl/stride_pf_table.sv
module stride_pf_table #(
  parameter int PC_W      = 32,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 4,
  parameter int PF_DEPTH  = 4,
  parameter int CNT_W     = 2,
  parameter int PF_THRESH = 2,
  parameter int Q_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W;
  localparam int QP_W    = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [QP_W:0]    Q_FULL  = (QP_W+1)'(Q_DEPTH);

  logic              ent_v      [ENTRIES];
  logic [TAG_W-1:0]  ent_tag    [ENTRIES];
  logic [ADDR_W-1:0] ent_last   [ENTRIES];
  logic [ADDR_W-1:0] ent_stride [ENTRIES];
  logic [CNT_W-1:0]  ent_cnt    [ENTRIES];

  logic [ADDR_W-1:0] q_mem [Q_DEPTH];
  logic [QP_W-1:0]   wr_ptr, rd_ptr;
  logic [QP_W:0]     q_cnt;

  wire [IDX_W-1:0]  idx  = acc_pc[IDX_W-1:0];
  wire [TAG_W-1:0]  tag  = acc_pc[PC_W-1:IDX_W];
  wire              hit  = ent_v[idx] && (ent_tag[idx] == tag);
  wire [ADDR_W-1:0] diff = acc_addr - ent_last[idx];
  wire              same = (diff == ent_stride[idx]);
  wire [CNT_W-1:0]  cnt_old = ent_cnt[idx];

  logic [CNT_W-1:0]  cnt_new;
  logic [ADDR_W-1:0] stride_new;

  always_comb begin
    if (same) cnt_new = (cnt_old == CNT_MAX) ? cnt_old : cnt_old + 1'b1;
    else      cnt_new = (cnt_old == '0) ? '0 : cnt_old - 1'b1;
    stride_new = (!same && cnt_new == '0) ? diff : ent_stride[idx];
  end

  wire              pf_want   = acc_valid && hit && (cnt_new >= CNT_W'(PF_THRESH))
                                && (stride_new != '0);
  wire [ADDR_W-1:0] pf_target = acc_addr + stride_new * ADDR_W'(PF_DEPTH);
  wire              push      = pf_want && (q_cnt != Q_FULL);
  wire              pop       = (q_cnt != '0) && !acc_valid;

  assign pf_valid = pop;
  assign pf_addr  = q_mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_v[i] <= 1'b0;
    end else if (acc_valid) begin
      ent_v[idx]      <= 1'b1;
      ent_tag[idx]    <= tag;
      ent_last[idx]   <= acc_addr;
      ent_stride[idx] <= hit ? stride_new : '0;
      ent_cnt[idx]    <= hit ? cnt_new : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      q_cnt  <= '0;
    end else begin
      if (push) begin
        q_mem[wr_ptr] <= pf_target;
        wr_ptr <= (wr_ptr == QP_W'(Q_DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == QP_W'(Q_DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      q_cnt <= q_cnt + (push ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
    end
  end

  p_hold_during_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> q_cnt >= $past(q_cnt));
  p_pop_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |=> q_cnt == $past(q_cnt) - 1'b1);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= Q_FULL);
  p_full_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && q_cnt == Q_FULL) |=> q_cnt == Q_FULL);
  p_alloc_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !hit) |=> (ent_cnt[$past(idx)] == '0) && (ent_stride[$past(idx)] == '0));
  p_zero_stride_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && hit && ent_stride[idx] == '0 && acc_addr == ent_last[idx])
    |=> q_cnt == $past(q_cnt));
endmodule

// File: tb/stride_pf_table_tb_top.sv
module stride_pf_table_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_pc = '0;
  logic [31:0] acc_addr = '0;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_addr [$];
  string       exp_tag  [$];

  always #2 clk = ~clk;

  stride_pf_table dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_pc(acc_pc),
    .acc_addr(acc_addr), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  task automatic acc(input logic [31:0] pc, input logic [31:0] addr,
                     input bit e, input logic [31:0] ea, input string tag);
    @(posedge clk); #1;
    acc_valid = 1'b1; acc_pc = pc; acc_addr = addr;
    if (e) begin exp_addr.push_back(ea); exp_tag.push_back(tag); end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      acc_valid = 1'b0;
    end
  endtask

  task automatic drained(input string tag);
    n_chk++;
    if (exp_addr.size() != 0) begin
      n_bad++;
      $display("FAIL %s: %0d expected prefetches missing (expected 0)", tag, exp_addr.size());
      exp_addr.delete(); exp_tag.delete();
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (acc_valid) begin
        n_chk++;
        if (pf_valid) begin
          n_bad++;
          $display("FAIL R7: pf_valid=%b during access (expected 0)", pf_valid);
        end
      end
      if (pf_valid) begin
        n_chk++;
        if (exp_addr.size() == 0) begin
          n_bad++;
          $display("FAIL R5/R6: unexpected prefetch %h (expected none)", pf_addr);
        end else begin
          automatic logic [31:0] e = exp_addr.pop_front();
          automatic string t = exp_tag.pop_front();
          if (pf_addr !== e) begin
            n_bad++;
            $display("FAIL %s: pf_addr=%h expected %h", t, pf_addr, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung (expected completion)");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (pf_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: pf_valid=%b after reset expected 0", pf_valid);
    end

    // R3 R4 R5: train stride 16, then break it until the stride is relearned
    acc(32'h100, 32'h1000, 0, 0, "R1"); idle(2);
    acc(32'h100, 32'h1010, 0, 0, "R3"); idle(2);
    acc(32'h100, 32'h1020, 0, 0, "R4"); idle(2);
    acc(32'h100, 32'h1030, 1, 32'h1070, "R5 count 2"); idle(2);
    acc(32'h100, 32'h1040, 1, 32'h1080, "R5 count 3"); idle(2);
    acc(32'h100, 32'h1050, 1, 32'h1090, "R4 saturate"); idle(2);
    acc(32'h100, 32'h2000, 1, 32'h2040, "R4 decrement to 2"); idle(2);
    acc(32'h100, 32'h3000, 0, 0, "R4"); idle(2);
    acc(32'h100, 32'h4000, 0, 0, "R4"); idle(2);
    acc(32'h100, 32'h5000, 0, 0, "R4"); idle(2);
    acc(32'h100, 32'h6000, 1, 32'hA000, "R4 relearned stride"); idle(3);
    drained("R5");

    // R6: repeated address, counter climbs but stride is zero
    for (int k = 0; k < 6; k++) begin acc(32'h204, 32'h500, 0, 0, "R6"); idle(2); end
    idle(3);
    drained("R6");

    // R9: three interleaved streams, back to back
    for (int r = 0; r < 4; r++) begin
      acc(32'h301, 32'h10000 + r * 8, r == 3, 32'h10038, "R9 stream A");
      acc(32'h302, 32'h20000 + r * 32'h100, r == 3, 32'h20700, "R9 stream X");
      acc(32'h303, 32'h30000 - r * 4, r == 3, 32'h2FFE4, "R9 stream Y");
    end
    idle(6);
    drained("R9");

    // R2: aliasing program counter replaces the entry
    acc(32'h110, 32'h7000, 0, 0, "R2"); idle(2);
    acc(32'h100, 32'h7000, 0, 0, "R2"); idle(2);
    acc(32'h100, 32'h8000, 0, 0, "R2"); idle(3);
    drained("R2");

    // R8: burst of six prefetching accesses, last two dropped
    acc(32'h405, 32'h000, 0, 0, "R8"); idle(2);
    acc(32'h405, 32'h040, 0, 0, "R8"); idle(2);
    acc(32'h405, 32'h080, 0, 0, "R8"); idle(2);
    acc(32'h405, 32'h0C0, 1, 32'h1C0, "R8 first");
    acc(32'h405, 32'h100, 1, 32'h200, "R8 second");
    acc(32'h405, 32'h140, 1, 32'h240, "R8 third");
    acc(32'h405, 32'h180, 1, 32'h280, "R8 fourth");
    acc(32'h405, 32'h1C0, 0, 0, "R8 dropped");
    acc(32'h405, 32'h200, 0, 0, "R8 dropped");
    idle(8);
    drained("R8");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule